// File: doc/BRIEF.md
# One-Time-Programmable Block Guard

This block sits between a requester and a flash program/erase engine. It makes any block of the array write-once. Each block has an enable bit. When the bit is active, erase requests for that block are refused. A program request for that block is forwarded only if the addressed 64-bit doubleword still holds the erased pattern 0xFFFF_FFFF_FFFF_FFFF. Blocks without an active enable pass every request through unchanged.

Enable requests can arrive at any moment on a configuration input. They are held in a sticky pending register. They are merged into the active mask only while the functional reset is asserted, so a new assignment acts after the next reset. Nothing but power-on reset can clear an active bit.

A request travels through these states: IDLE (accept) → FETCH (read the target doubleword) → DECIDE (grant or refuse) → either REFUSE (one-cycle error response) or ISSUE (one-cycle strobe to the engine) → WAIT (until the engine signals done) → GRANT (one-cycle success response) → IDLE. The transitions are:
- IDLE→FETCH when a request is accepted.
- FETCH→DECIDE unconditionally.
- DECIDE→REFUSE or DECIDE→ISSUE according to the protection rule.
- ISSUE→WAIT unconditionally.
- WAIT→GRANT on engine done.
- REFUSE→IDLE and GRANT→IDLE unconditionally.

Top module: `otp_block_guard`

## Requirements
- R1: A pulse on `cfg_otp_set[b]` is remembered. It has no effect on requests until the next functional reset (`rst_n` low). After that reset, block b is protected.
- R2: An erase (`req_op`=1) to a protected block is refused with `resp_err`=1. `fl_erase` is never pulsed for it, and the array content is unchanged.
- R3: A program (`req_op`=0) to a protected block whose target doubleword reads all ones is forwarded on `fl_prog`, with the request's address and data, and answered with `resp_err`=0.
- R4: A program to a protected block whose target doubleword is not all ones is refused with `resp_err`=1. This holds even when the new data would only clear further bits. No `fl_prog` pulse occurs and the word is unchanged.
- R5: The active protection mask changes only in the cycle after `rst_n` was sampled low. An enable set while running does not protect its block before that.
- R6: No input path clears an active enable bit. A later functional reset without any new set leaves earlier protected blocks protected. Only `por_n` clears both the pending and the active bits.
- R7: A refused request raises `resp_valid` with `resp_err` in the cycle straight after DECIDE, three clock edges after acceptance. No strobe to the engine occurs in that request.
- R8: Requests to unprotected blocks are forwarded unchanged. This includes re-programming an already programmed doubleword and erasing the block.
- R9: Every program issues exactly one read on `rd_en` one cycle after acceptance, and an erase issues none. `fl_prog` comes two cycles after that read. `req_ready` is high only in IDLE.
- R10: The block index is the upper `$clog2(NUM_BLOCKS)` bits of the doubleword address `req_addr`. The lower `WORD_IDX_W` bits select the doubleword inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears pending and active enables |
| rst_n | input | 1 | Functional reset, active low, synchronous; returns the FSM to IDLE and promotes pending enables |
| cfg_otp_set | input | NUM_BLOCKS | Enable request per block from the configuration record path |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Guard idle and able to accept |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_addr | input | ADDR_W | Doubleword address {block, word} |
| req_data | input | 64 | Program data |
| rd_en | output | 1 | Read strobe to the array read port |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | 64 | Read data, valid one cycle after rd_en |
| fl_prog | output | 1 | One-cycle program strobe to the engine |
| fl_erase | output | 1 | One-cycle block erase strobe to the engine |
| fl_addr | output | ADDR_W | Address forwarded to the engine |
| fl_data | output | 64 | Data forwarded to the engine |
| fl_done | input | 1 | Engine completion pulse |
| resp_valid | output | 1 | One-cycle response |
| resp_err | output | 1 | Response reports a refusal |

## Verification
On every cycle, the embedded properties check several things:
- the active mask never loses a bit and moves only after a functional reset;
- erase strobes never target a protected block;
- a program strobe on a protected block follows a blank read two cycles earlier;
- a refusal never coincides with a strobe.

Only the directed scenarios can show the end-to-end behaviour. These include:
- a pending enable leaving the block writable until reset;
- an over-program that would only clear bits being refused with the word intact;
- neighbouring blocks sharing word offsets staying free;
- protection surviving repeated resets.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECIDE,
        ST_ISSUE,
        ST_WAIT,
        ST_GRANT,
        ST_REFUSE
    } state_e;

    localparam int DWORD_BITS = 64;

endpackage

// File: rtl/otp_enable_bank.sv
module otp_enable_bank #(
    parameter int NUM_BLOCKS = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] set_i,
    output logic [NUM_BLOCKS-1:0] active_o
);

    logic [NUM_BLOCKS-1:0] pending_q;
    logic [NUM_BLOCKS-1:0] active_q;

    // Pending requests are sticky; they reach the active mask only while
    // the functional reset is held.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            pending_q <= pending_q | set_i;
            if (!rst_n) begin
                active_q <= active_q | pending_q;
            end
        end
    end

    assign active_o = active_q;

    AST_ACTIVE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (($past(active_q) & ~active_q) == '0)) else $error("active bit cleared"); // R6

    AST_ACTIVE_MOVES_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        $past(rst_n) |-> $stable(active_q)) else $error("active changed outside reset"); // R5

endmodule

// File: rtl/otp_blank_detect.sv
module otp_blank_detect #(
    parameter int WIDTH = 64,
    parameter int LANES = 4
) (
    input  logic [WIDTH-1:0] data_i,
    output logic             blank_o
);

    localparam int LANE_W = WIDTH / LANES;

    logic [LANES-1:0] lane_ones;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane_ones[g] = &data_i[g*LANE_W +: LANE_W];
        end
    endgenerate

    assign blank_o = &lane_ones;

endmodule

// File: rtl/otp_guard_fsm.sv
module otp_guard_fsm
    import otp_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3,
    parameter int ADDR_W     = 7
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] active_i,
    input  logic                  blank_i,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DWORD_BITS-1:0] req_data,
    output logic                  rd_en,
    output logic [ADDR_W-1:0]     rd_addr,
    output logic                  fl_prog,
    output logic                  fl_erase,
    output logic [ADDR_W-1:0]     fl_addr,
    output logic [DWORD_BITS-1:0] fl_data,
    input  logic                  fl_done,
    output logic                  resp_valid,
    output logic                  resp_err
);

    state_e                state_q, state_d;
    op_e                   op_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [DWORD_BITS-1:0] data_q;
    logic                  lock_q;
    logic [BLK_W-1:0]      req_blk;
    logic                  accept;

    assign req_blk = req_addr[ADDR_W-1 -: BLK_W];
    assign accept  = (state_q == ST_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_IDLE;
        end else if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, taken on acceptance
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            lock_q <= 1'b0;
        end else if (accept) begin
            op_q   <= op_e'(req_op);
            addr_q <= req_addr;
            data_q <= req_data;
            lock_q <= active_i[req_blk];
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (op_q == OP_ERASE) begin
                    state_d = lock_q ? ST_REFUSE : ST_ISSUE;
                end else begin
                    state_d = (!lock_q || blank_i) ? ST_ISSUE : ST_REFUSE;
                end
            end
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   if (fl_done) state_d = ST_GRANT;
            ST_GRANT:  state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        rd_en      = 1'b0;
        fl_prog    = 1'b0;
        fl_erase   = 1'b0;
        resp_valid = 1'b0;
        resp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_FETCH:  rd_en = (op_q == OP_PROG);
            ST_DECIDE: ;
            ST_ISSUE: begin
                fl_prog  = (op_q == OP_PROG);
                fl_erase = (op_q == OP_ERASE);
            end
            ST_WAIT:   ;
            ST_GRANT:  resp_valid = 1'b1;
            ST_REFUSE: begin
                resp_valid = 1'b1;
                resp_err   = 1'b1;
            end
            default:   ;
        endcase
    end

    assign rd_addr = addr_q;
    assign fl_addr = addr_q;
    assign fl_data = data_q;

    AST_ERASE_NEVER_LOCKED: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        fl_erase |-> !active_i[fl_addr[ADDR_W-1 -: BLK_W]]) else $error("erase on protected block"); // R2

    AST_PROG_LOCKED_NEEDS_BLANK: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (fl_prog && lock_q) |-> $past(blank_i)) else $error("program on non-blank protected word"); // R4

    AST_REFUSE_NO_STROBE: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (resp_valid && resp_err) |-> (!fl_prog && !fl_erase && $past(state_q == ST_DECIDE)))
        else $error("refusal timing or strobe"); // R7

    AST_PROG_AFTER_READ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        fl_prog |-> $past(rd_en, 2)) else $error("program without prior read"); // R9

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $onehot0({fl_prog, fl_erase, rd_en})) else $error("strobes overlap"); // R9

endmodule

// File: rtl/otp_block_guard.sv
module otp_block_guard
    import otp_guard_pkg::*;
#(
    parameter int  NUM_BLOCKS = 8,
    parameter int  WORD_IDX_W = 4,
    localparam int BLK_W      = $clog2(NUM_BLOCKS),
    localparam int ADDR_W     = BLK_W + WORD_IDX_W
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] cfg_otp_set,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [63:0]           req_data,
    output logic                  rd_en,
    output logic [ADDR_W-1:0]     rd_addr,
    input  logic [63:0]           rd_data,
    output logic                  fl_prog,
    output logic                  fl_erase,
    output logic [ADDR_W-1:0]     fl_addr,
    output logic [63:0]           fl_data,
    input  logic                  fl_done,
    output logic                  resp_valid,
    output logic                  resp_err
);

    logic [NUM_BLOCKS-1:0] active_mask;
    logic                  word_blank;

    otp_enable_bank #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_bank (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .set_i    (cfg_otp_set),
        .active_o (active_mask)
    );

    otp_blank_detect #(
        .WIDTH (DWORD_BITS),
        .LANES (4)
    ) u_blank (
        .data_i  (rd_data),
        .blank_o (word_blank)
    );

    otp_guard_fsm #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W),
        .ADDR_W     (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .active_i   (active_mask),
        .blank_i    (word_blank),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .fl_prog    (fl_prog),
        .fl_erase   (fl_erase),
        .fl_addr    (fl_addr),
        .fl_data    (fl_data),
        .fl_done    (fl_done),
        .resp_valid (resp_valid),
        .resp_err   (resp_err)
    );

    AST_RESP_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        resp_valid |-> !req_ready) else $error("response while idle"); // R9

endmodule

// File: tb/otp_block_guard_test.sv
module otp_block_guard_test;

    localparam int NB = 4;
    localparam int WI = 3;
    localparam int AW = 5;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] cfg_otp_set = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_data = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [63:0]   rd_data;
    logic          fl_prog, fl_erase;
    logic [AW-1:0] fl_addr;
    logic [63:0]   fl_data;
    logic          fl_done;
    logic          resp_valid, resp_err;

    int errors = 0;
    int checks = 0;
    int n_prog = 0, n_erase = 0, n_rd = 0;
    logic [AW-1:0] last_addr;
    logic [63:0]   last_data;
    bit finished = 0;

    always #10 clk = ~clk;

    otp_block_guard #(.NUM_BLOCKS(NB), .WORD_IDX_W(WI)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_otp_set(cfg_otp_set),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .fl_prog(fl_prog), .fl_erase(fl_erase), .fl_addr(fl_addr),
        .fl_data(fl_data), .fl_done(fl_done), .resp_valid(resp_valid), .resp_err(resp_err)
    );

    // Behavioural array and engine: programming clears bits, erase sets a block.
    logic [63:0] mem [NB*(1<<WI)];
    logic        done_pipe;

    initial begin
        for (int i = 0; i < NB*(1<<WI); i++) mem[i] = ONES;
    end

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            n_rd <= n_rd + 1;
        end
        if (fl_prog) begin
            mem[fl_addr] <= mem[fl_addr] & fl_data;
            n_prog <= n_prog + 1;
            last_addr <= fl_addr;
            last_data <= fl_data;
        end
        if (fl_erase) begin
            for (int i = 0; i < (1<<WI); i++) mem[{fl_addr[AW-1:WI], i[WI-1:0]}] <= ONES;
            n_erase <= n_erase + 1;
        end
        done_pipe <= fl_prog | fl_erase;
        fl_done   <= done_pipe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int blk, input int wrd);
        return {blk[AW-WI-1:0], wrd[WI-1:0]};
    endfunction

    task automatic send(input logic op, input logic [AW-1:0] addr, input logic [63:0] data,
                        output logic err, output int lat, output logic busy_ready);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
        lat = 0; err = 1'b0; busy_ready = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
            if (lat == 1) busy_ready = req_ready;
            if (resp_valid) begin
                err = resp_err;
                break;
            end
        end
    endtask

    task automatic func_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_set(input logic [NB-1:0] m);
        @(negedge clk); cfg_otp_set = m;
        @(negedge clk); cfg_otp_set = '0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready after reset", {63'd0, req_ready}, 64'd1);
        chk({resp_valid, fl_prog, fl_erase, rd_en} === 4'b0, "R9 outputs idle after reset",
            {60'd0, resp_valid, fl_prog, fl_erase, rd_en}, 64'd0);
    endtask

    task automatic t_unprotected_pass();
        logic e, br; int lat; int p0, r0, x0;
        p0 = n_prog; r0 = n_rd;
        send(1'b0, mk(2,3), 64'h0123_4567_89AB_CDEF, e, lat, br);
        chk(e === 1'b0, "R8 unprotected program accepted", {63'd0, e}, 64'd0);
        chk(last_addr === mk(2,3) && last_data === 64'h0123_4567_89AB_CDEF,
            "R8 address and data forwarded", last_data, 64'h0123_4567_89AB_CDEF);
        chk(n_rd == r0 + 1, "R9 one read per program", n_rd - r0, 1);
        chk(br === 1'b0, "R9 not ready while busy", {63'd0, br}, 64'd0);
        send(1'b0, mk(2,3), 64'h0000_FFFF_0000_FFFF, e, lat, br);
        chk(e === 1'b0 && n_prog == p0 + 2, "R8 over-program passes on free block", n_prog - p0, 2);
        chk(mem[mk(2,3)] === 64'h0000_4567_0000_CDEF, "R8 word content", mem[mk(2,3)], 64'h0000_4567_0000_CDEF);
        r0 = n_rd; x0 = n_erase;
        send(1'b1, mk(2,0), '0, e, lat, br);
        chk(e === 1'b0 && n_erase == x0 + 1, "R8 erase on free block", n_erase - x0, 1);
        chk(n_rd == r0, "R9 erase issues no read", n_rd - r0, 0);
        chk(mem[mk(2,3)] === ONES, "R8 erase restored ones", mem[mk(2,3)], ONES);
    endtask

    task automatic t_pending_inert();
        logic e, br; int lat;
        pulse_set(4'b0010);
        send(1'b0, mk(1,0), 64'h1111_2222_3333_4444, e, lat, br);
        chk(e === 1'b0, "R1 pending enable does not protect", {63'd0, e}, 64'd0);
        send(1'b1, mk(1,0), '0, e, lat, br);
        chk(e === 1'b0 && mem[mk(1,0)] === ONES, "R5 erase still allowed before reset", mem[mk(1,0)], ONES);
    endtask

    task automatic t_protected_blank_prog();
        logic e, br; int lat; int p0;
        p0 = n_prog;
        send(1'b0, mk(1,5), 64'hDEAD_BEEF_0F0F_F0F0, e, lat, br);
        chk(e === 1'b0 && n_prog == p0 + 1, "R3 blank word programmable", {63'd0, e}, 64'd0);
        chk(mem[mk(1,5)] === 64'hDEAD_BEEF_0F0F_F0F0, "R3 word written", mem[mk(1,5)], 64'hDEAD_BEEF_0F0F_F0F0);
    endtask

    task automatic t_protected_erase();
        logic e, br; int lat; int x0;
        x0 = n_erase;
        send(1'b1, mk(1,2), '0, e, lat, br);
        chk(e === 1'b1, "R2 erase refused", {63'd0, e}, 64'd1);
        chk(n_erase == x0, "R2 no erase strobe", n_erase - x0, 0);
        chk(lat == 3, "R7 refusal latency", lat, 3);
        chk(mem[mk(1,5)] === 64'hDEAD_BEEF_0F0F_F0F0, "R2 content kept", mem[mk(1,5)], 64'hDEAD_BEEF_0F0F_F0F0);
    endtask

    task automatic t_overprogram();
        logic e, br; int lat; int p0;
        p0 = n_prog;
        send(1'b0, mk(1,5), 64'h0EAD_BEEF_0F0F_F0F0, e, lat, br);
        chk(e === 1'b1, "R4 over-program refused", {63'd0, e}, 64'd1);
        chk(n_prog == p0, "R7 no program strobe on refusal", n_prog - p0, 0);
        chk(lat == 3, "R7 refusal latency on program", lat, 3);
        chk(mem[mk(1,5)] === 64'hDEAD_BEEF_0F0F_F0F0, "R4 word unchanged", mem[mk(1,5)], 64'hDEAD_BEEF_0F0F_F0F0);
    endtask

    task automatic t_neighbour_blocks();
        logic e, br; int lat;
        send(1'b0, mk(0,5), 64'hAAAA_AAAA_AAAA_AAAA, e, lat, br);
        send(1'b0, mk(0,5), 64'h0000_AAAA_AAAA_AAAA, e, lat, br);
        chk(e === 1'b0, "R10 same offset in block 0 stays free", {63'd0, e}, 64'd0);
        send(1'b1, mk(3,5), '0, e, lat, br);
        chk(e === 1'b0, "R10 block 3 erase free", {63'd0, e}, 64'd0);
    endtask

    task automatic t_no_revoke();
        logic e, br; int lat;
        func_reset();
        send(1'b1, mk(1,0), '0, e, lat, br);
        chk(e === 1'b1, "R6 protection survives reset", {63'd0, e}, 64'd1);
        pulse_set(4'b0100);
        send(1'b1, mk(2,0), '0, e, lat, br);
        chk(e === 1'b0, "R5 new enable inert while running", {63'd0, e}, 64'd0);
        func_reset();
        send(1'b1, mk(2,0), '0, e, lat, br);
        chk(e === 1'b1, "R1 block 2 protected after reset", {63'd0, e}, 64'd1);
        send(1'b1, mk(1,0), '0, e, lat, br);
        chk(e === 1'b1, "R6 block 1 still protected", {63'd0, e}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_unprotected_pass();
        t_pending_inert();
        func_reset();
        t_protected_blank_prog();
        t_protected_erase();
        t_overprogram();
        t_neighbour_blocks();
        t_no_revoke();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule